// File: doc/BRIEF.md
# Double-Buffered Configuration Context Store

This block keeps two copies of a reconfigurable fabric's configuration. The active copy drives the compute logic through `cfg_o`. The shadow copy is a serial scan path: a new context is shifted into it word by word while the active copy keeps working unchanged. A single-cycle swap then exchanges the two copies for every domain at once. The context that was running ends up in the shadow path, so it can be shifted out for preemption. That shifting is the same motion that loads the next context, and both happen together.

The scan path is cut into `NUM_DOM` independent domains. Each domain has its own shift enable, serial input word and serial output word, so all domains load in parallel. A commanded shift length is loaded into a count in every domain. A busy flag and a one-cycle done flag report when every domain has made that many shifts.

Top module: `ctx_swap_store`

## Requirements
- R1: While `rst_ni` is low and after its release, every shadow and active bit is 0, so `cfg_o` and `scan_out_o` are 0, and `busy_o` and `done_o` are 0.
- R2: Word k of domain d occupies `cfg_o[d*DOM_WORDS*WORD_W + k*WORD_W +: WORD_W]`, and its serial ports are `scan_in_i`/`scan_out_o[d*WORD_W +: WORD_W]`. A shift happens in domain d at a clock edge where `shift_en_i[d]`=1 and `swap_i`=0. In a shift, shadow word k takes word k+1, and the top word `DOM_WORDS-1` takes `scan_in_i`. Shifting never changes `cfg_o`.
- R3: At a clock edge with `swap_i`=1, every domain's active and shadow contents exchange. From the next cycle, `cfg_o` shows the former shadow contents and the shadow path holds the former active contents.
- R4: `scan_out_o` always shows shadow word 0 of each domain, with no added delay. After a swap, the outgoing context comes out word 0 first, one word per shift, while the next context enters.
- R5: A swap between identical active and shadow contents leaves `cfg_o` constant through the swap cycle.
- R6: When `swap_i` and `shift_en_i` are both high, the swap is done and the shift is stalled. The shadow data is not shifted, and no pending shift count is decremented.
- R7: A cycle with `start_i`=1 loads `len_i` into every domain's count. In that cycle the load takes precedence, and a shift in that cycle is not counted. Each later shift of a domain decrements its nonzero count. `busy_o` is 1 while any count is nonzero. `done_o` is 1 for exactly the one cycle after `busy_o` falls. A `len_i` of 0 leaves `busy_o` low.
- R8: Domains shift independently. A domain whose shift enable is low keeps its shadow word 0 on `scan_out_o`, and its count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_en_i | input | NUM_DOM | Shift enable, one bit per domain |
| scan_in_i | input | NUM_DOM*WORD_W | Serial input word per domain |
| scan_out_o | output | NUM_DOM*WORD_W | Shadow word 0 per domain |
| swap_i | input | 1 | Exchange active and shadow contents |
| start_i | input | 1 | Load the shift command count |
| len_i | input | LEN_W | Number of words in the commanded shift |
| busy_o | output | 1 | Some domain still owes shifts |
| done_o | output | 1 | One-cycle pulse after the command completes |
| cfg_o | output | NUM_DOM*DOM_WORDS*WORD_W | Active configuration |

## Verification
`cfg_o`, the shadow contents and the counts are registers, so the effect of a shift, swap or start appears one clock edge after the command. `scan_out_o` and `busy_o` are read from registers with no added logic delay, and `done_o` is one register later than the count reaching zero. The bench drives inputs shortly after a rising edge and samples one edge later. It compares `scan_out_o` against the expected outgoing word before each shift edge and compares `cfg_o` after each edge. Because it checks on every cycle of a load, the current context is shown to stay in place while the next one is shifted in.

// File: rtl/ctx_swap_pkg.sv
package ctx_swap_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_SWAP  = 2'd2
  } dom_op_e;
endpackage

// File: rtl/ctx_swap_domain.sv
module ctx_swap_domain
  import ctx_swap_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WORD_W = 2,
  localparam int BITS  = WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dom_op_e           op_i,
  input  logic [WORD_W-1:0] scan_i,
  output logic [WORD_W-1:0] scan_o,
  output logic [BITS-1:0]   cfg_o,
  output logic [BITS-1:0]   shadow_o
);
  logic [BITS-1:0] shadow_q, active_q, shadow_sh;

  // new word enters at the top, word 0 leaves
  generate
    if (WORDS == 1) begin : g_single
      assign shadow_sh = scan_i;
    end else begin : g_multi
      assign shadow_sh = {scan_i, shadow_q[BITS-1:WORD_W]};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      case (op_i)
        OP_SHIFT: shadow_q <= shadow_sh;
        OP_SWAP: begin
          shadow_q <= active_q;
          active_q <= shadow_q;
        end
        default: ;
      endcase
    end
  end

  assign scan_o   = shadow_q[WORD_W-1:0];
  assign cfg_o    = active_q;
  assign shadow_o = shadow_q;
endmodule

// File: rtl/ctx_swap_cnt.sv
module ctx_swap_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dec_i,
  output logic             busy_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= len_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ctx_swap_store.sv
module ctx_swap_store
  import ctx_swap_pkg::*;
#(
  parameter int NUM_DOM   = 2,
  parameter int DOM_WORDS = 4,
  parameter int WORD_W    = 2,
  parameter int LEN_W     = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_DOM-1:0]                  shift_en_i,
  input  logic [NUM_DOM*WORD_W-1:0]           scan_in_i,
  output logic [NUM_DOM*WORD_W-1:0]           scan_out_o,
  input  logic                                swap_i,
  input  logic                                start_i,
  input  logic [LEN_W-1:0]                    len_i,
  output logic                                busy_o,
  output logic                                done_o,
  output logic [NUM_DOM*DOM_WORDS*WORD_W-1:0] cfg_o
);
  localparam int DOM_BITS = DOM_WORDS * WORD_W;
  localparam int CFG_W    = NUM_DOM * DOM_BITS;

  logic [CFG_W-1:0]   shadow_all;
  logic [NUM_DOM-1:0] dom_busy;
  logic               busy_d1_q;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    dom_op_e op;
    logic    do_shift;

    // swap wins over shift
    assign do_shift = shift_en_i[d] && !swap_i;
    assign op = swap_i ? OP_SWAP : (do_shift ? OP_SHIFT : OP_HOLD);

    ctx_swap_domain #(
      .WORDS (DOM_WORDS),
      .WORD_W(WORD_W)
    ) i_dom (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (op),
      .scan_i  (scan_in_i[d*WORD_W +: WORD_W]),
      .scan_o  (scan_out_o[d*WORD_W +: WORD_W]),
      .cfg_o   (cfg_o[d*DOM_BITS +: DOM_BITS]),
      .shadow_o(shadow_all[d*DOM_BITS +: DOM_BITS])
    );

    ctx_swap_cnt #(
      .LEN_W(LEN_W)
    ) i_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(start_i),
      .len_i (len_i),
      .dec_i (do_shift),
      .busy_o(dom_busy[d])
    );
  end

  assign busy_o = |dom_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_d1_q <= 1'b0;
    else         busy_d1_q <= busy_o;
  end

  assign done_o = busy_d1_q && !busy_o;
endmodule

// File: rtl/ctx_swap_chk.sv
module ctx_swap_chk #(
  parameter int NUM_DOM = 2,
  parameter int CFG_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               swap_i,
  input logic [NUM_DOM-1:0] shift_en_i,
  input logic [CFG_W-1:0]   cfg_o,
  input logic [CFG_W-1:0]   shadow_i,
  input logic               busy_o,
  input logic               done_o
);
  a_r3_swap_loads_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> cfg_o == $past(shadow_i));

  a_r3_swap_keeps_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> shadow_i == $past(cfg_o));

  a_r2_active_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_i |=> $stable(cfg_o));

  a_r5_equal_no_disturb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && shadow_i == cfg_o) |=> $stable(cfg_o));

  a_r8_idle_shadow_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!swap_i && shift_en_i == '0) |=> $stable(shadow_i));

  a_r7_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind ctx_swap_store ctx_swap_chk #(
  .NUM_DOM(NUM_DOM),
  .CFG_W  (CFG_W)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .swap_i    (swap_i),
  .shift_en_i(shift_en_i),
  .cfg_o     (cfg_o),
  .shadow_i  (shadow_all),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/test_ctx_swap_store.sv
module test_ctx_swap_store;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 2, NW = 4, WW = 2, LW = 8;
  localparam int DB = NW * WW;

  typedef struct packed {
    logic [15:0] ctx;
    logic [3:0]  exp_out;  // {dom1 word0, dom0 word0} of outgoing context after swap
  } vec_t;

  localparam vec_t TAB [4] = '{
    '{16'hA5C3, 4'b0000},
    '{16'h0F1E, 4'b0111},
    '{16'h3C96, 4'b1110},
    '{16'h7B29, 4'b0010}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ND-1:0] shift_en = '0;
  logic [ND*WW-1:0] scan_in = '0, scan_out;
  logic swap = 1'b0, start = 1'b0, busy, done;
  logic [LW-1:0] len = '0;
  logic [ND*DB-1:0] cfg;
  int n_chk = 0, n_fail = 0;
  logic [15:0] act_ref = '0, sh_ref = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_swap_store #(.NUM_DOM(ND), .DOM_WORDS(NW), .WORD_W(WW), .LEN_W(LW)) i_ctx_swap_store (
    .clk_i(clk), .rst_ni(rst_n), .shift_en_i(shift_en), .scan_in_i(scan_in),
    .scan_out_o(scan_out), .swap_i(swap), .start_i(start), .len_i(len),
    .busy_o(busy), .done_o(done), .cfg_o(cfg)
  );

  function automatic logic [1:0] wd(logic [15:0] v, int d, int k);
    return v[d*DB + k*WW +: WW];
  endfunction

  function automatic logic [3:0] pair(logic [15:0] v, int k);
    return {wd(v, 1, k), wd(v, 0, k)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R1 cfg", cfg, 0);
    check("R1 scan_out", scan_out, 0);
    check("R1 busy", busy, 0);
    rst_n = 1'b1;
    tick();
    check("R1 done", done, 0);

    foreach (TAB[i]) begin
      start = 1'b1; len = 8'd4; shift_en = '1;  // shift not counted, R7
      scan_in = pair(TAB[i].ctx, 0);
      tick();
      start = 1'b0;
      check("R7 busy after start", busy, 1);
      // the start cycle shifted word 0; reload it with the full sequence below
      for (int k = 0; k < NW; k++) begin
        scan_in = pair(TAB[i].ctx, k);
        tick();
        check("R2 cfg during load", cfg, act_ref);
      end
      shift_en = '0;
      check("R7 busy low", busy, 0);
      check("R7 done pulse", done, 1);
      swap = 1'b1;
      tick();
      swap = 1'b0;
      sh_ref = act_ref; act_ref = TAB[i].ctx;
      check("R3 cfg after swap", cfg, TAB[i].ctx);
      check("R4 outgoing word 0", scan_out, TAB[i].exp_out);
      check("R7 done single", done, 0);
      // extract outgoing context while loading the same words back (R4)
      shift_en = '1;
      for (int k = 0; k < NW; k++) begin
        check("R4 extract word", scan_out, pair(sh_ref, k));
        scan_in = pair(sh_ref, k);
        tick();
      end
      shift_en = '0;
    end

    // R6: swap with shift in same cycle
    start = 1'b1; len = 8'd1; tick(); start = 1'b0;
    swap = 1'b1; shift_en = '1; scan_in = '1;
    tick();
    swap = 1'b0; shift_en = '0;
    check("R6 cfg swapped", cfg, sh_ref);
    check("R6 shift stalled", scan_out, pair(act_ref, 0));
    check("R6 count kept", busy, 1);
    swap = 1'b1; tick(); swap = 1'b0;
    check("R3 swap back", cfg, act_ref);

    // R8: per-domain shifting; shadow holds sh_ref
    shift_en = 2'b01; scan_in = '0;
    tick();
    shift_en = '0;
    check("R8 dom1 pending", busy, 1);
    check("R8 dom1 untouched", scan_out[3:2], wd(sh_ref, 1, 0));
    check("R8 dom0 shifted", scan_out[1:0], wd(sh_ref, 0, 1));
    shift_en = 2'b10;
    tick();
    shift_en = '0;
    check("R8 dom1 done", busy, 0);
    check("R7 done after dom1", done, 1);

    // R5: swap identical contexts
    shift_en = '1;
    for (int k = 0; k < NW; k++) begin
      scan_in = pair(act_ref, k);
      tick();
    end
    shift_en = '0;
    swap = 1'b1; tick(); swap = 1'b0;
    check("R5 cfg unchanged", cfg, act_ref);
    check("R5 shadow equal", scan_out, pair(act_ref, 0));

    // R7: zero length
    start = 1'b1; len = '0; tick(); start = 1'b0;
    check("R7 zero len busy", busy, 0);
    tick();
    check("R7 zero len done", done, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule